// File: doc/BRIEF.md
# Invalidation Acknowledgement Tracker

This block does the acknowledgement arithmetic for a directory-side coherence controller that keeps a sharer bit-vector per line. When the controller sends a grant, the block produces the signed acknowledgement count that goes into the response. The count is negative: it tells the receiver how many invalidation acks it must still collect. A receiver adds each ack's value to it and is done when the sum reaches zero. The block also produces the destination mask for the matching invalidations.

When the controller evicts a line itself, the block loads a pending counter with the number of current sharers. Each incoming ack carries a count. If the pending value minus that count is zero, the ack is the last one: the block pulses a final indication and clears the counter. Otherwise the block pulses a partial indication and lowers the counter by the carried amount. The test for zero is made on the value before the update. The controller drives all inputs every cycle, and the block holds no queue.

Top module: `inv_ack_tracker`

## Requirements
- R1: For response kind 0 (write data), `rsp_ack_cnt_o` equals minus the number of set bits in `sharers_i`, plus one when bit `req_id_i` of `sharers_i` is set. It is combinational and in two's complement of CNT_W bits.
- R2: For response kind 1 (upgrade grant), `rsp_ack_cnt_o` equals one minus the number of set bits in `sharers_i`, whatever the requester's bit is.
- R3: For response kind 2 (shared read data) and kind 3 (no response), `rsp_ack_cnt_o` is zero.
- R4: When `evict_load_i` is high at a rising edge, `pending_o` after that edge equals the population count of `sharers_i`.
- R5: When `ack_valid_i` is high and `evict_load_i` is low at an edge, and `pending_o` minus `ack_cnt_i` is zero, then after the edge `ack_final_o` is high, `ack_partial_o` is low and `pending_o` is zero.
- R6: When `ack_valid_i` is high and `evict_load_i` is low at an edge, and the difference is non-zero, then after the edge `ack_partial_o` is high, `ack_final_o` is low and `pending_o` holds the difference modulo 2^CNT_W.
- R7: `ack_final_o` and `ack_partial_o` are one-cycle pulses. Both are low after any edge at which no ack was taken.
- R8: When `evict_load_i` and `ack_valid_i` are both high at an edge, the load wins: `pending_o` takes the population count, the ack is discarded and neither pulse rises.
- R9: With `inv_mode_i` = 0 (write), `inv_mask_o` is `sharers_i` with bit `req_id_i` cleared. With `inv_mode_i` = 1 (eviction), it is `sharers_i` unchanged.
- R10: After synchronous reset, `pending_o` is zero and both pulses are low.
- R11: `sharer_cnt_o` is the population count of `sharers_i`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sharers_i | input | NODES | Sharer bit-vector of the line |
| req_id_i | input | ID_W | Requester node number |
| rsp_kind_i | input | 2 | Response kind: 0 write data, 1 upgrade, 2 shared read, 3 none |
| inv_mode_i | input | 1 | Mask mode: 0 write request, 1 eviction |
| evict_load_i | input | 1 | Load the pending counter from the sharer count |
| ack_valid_i | input | 1 | An acknowledgement arrives this cycle |
| ack_cnt_i | input | CNT_W | Signed count carried by the acknowledgement |
| rsp_ack_cnt_o | output | CNT_W | Signed ack count for the outgoing response |
| inv_mask_o | output | NODES | Invalidation destination mask |
| sharer_cnt_o | output | POP_W | Number of sharers |
| pending_o | output | CNT_W | Pending acknowledgement counter |
| ack_partial_o | output | 1 | Pulse: non-final ack taken |
| ack_final_o | output | 1 | Pulse: final ack taken |

## Verification
The bench sweeps every sharer vector of an 8-node configuration against every requester and every response kind. This catches a design that forgets the requester correction on write data and so makes the requester wait forever for an ack that never comes. It also catches one that applies the correction to upgrades only when the requester's bit is set, and one that leaks a non-zero count into shared reads. For every sharer vector it loads the counter and drains it one ack at a time. A design that tests for zero after subtracting, rather than before, would pulse final one ack early or late. Multi-count acks, a load that collides with an ack, and reset are driven as well. A design that lets the ack win the collision would leave the counter short and raise a stray pulse.

// File: rtl/inv_ack_pkg.sv
`timescale 1ns/1ps
package inv_ack_pkg;

    typedef enum logic [1:0] {
        RSP_WRITE_DATA  = 2'd0,
        RSP_UPGRADE     = 2'd1,
        RSP_SHARED_READ = 2'd2,
        RSP_NONE        = 2'd3
    } rsp_kind_e;

    typedef enum logic {
        MASK_WRITE = 1'b0,
        MASK_EVICT = 1'b1
    } mask_mode_e;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_PARTIAL = 2'd1,
        EV_FINAL   = 2'd2
    } ack_event_e;

    typedef struct packed {
        logic partial;
        logic final_ack;
    } ack_pulse_t;

    function automatic ack_pulse_t decode_event(input ack_event_e ev);
        ack_pulse_t p;
        p.partial   = (ev == EV_PARTIAL);
        p.final_ack = (ev == EV_FINAL);
        return p;
    endfunction

endpackage

// File: rtl/inv_popcount.sv
`timescale 1ns/1ps
module inv_popcount #(
    parameter int NODES = 8,
    parameter int POP_W = $clog2(NODES + 1)
) (
    input  logic [NODES-1:0] vec_i,
    output logic [POP_W-1:0] count_o
);
    logic [POP_W-1:0] acc [NODES+1];

    assign acc[0] = '0;

    generate
        for (genvar g = 0; g < NODES; g++) begin : g_sum
            assign acc[g+1] = acc[g] + POP_W'(vec_i[g]);
        end
    endgenerate

    assign count_o = acc[NODES];
endmodule

// File: rtl/inv_resp_calc.sv
`timescale 1ns/1ps
module inv_resp_calc
    import inv_ack_pkg::*;
#(
    parameter int NODES = 8,
    parameter int ID_W  = $clog2(NODES),
    parameter int POP_W = $clog2(NODES + 1),
    parameter int CNT_W = $clog2(NODES) + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NODES-1:0]        sharers_i,
    input  logic [ID_W-1:0]         req_id_i,
    input  rsp_kind_e               kind_i,
    input  mask_mode_e              mode_i,
    input  logic [POP_W-1:0]        popcnt_i,
    output logic signed [CNT_W-1:0] ack_cnt_o,
    output logic [NODES-1:0]        inv_mask_o
);
    logic [NODES-1:0]        req_onehot;
    logic                    req_is_sharer;
    logic signed [CNT_W-1:0] neg_count;

    generate
        for (genvar g = 0; g < NODES; g++) begin : g_dec
            assign req_onehot[g] = (req_id_i == ID_W'(g));
        end
    endgenerate

    assign req_is_sharer = |(req_onehot & sharers_i);
    assign neg_count     = -$signed(CNT_W'(popcnt_i));

    always_comb begin
        unique case (kind_i)
            RSP_WRITE_DATA: ack_cnt_o = neg_count + (req_is_sharer ? CNT_W'(1) : CNT_W'(0));
            RSP_UPGRADE:    ack_cnt_o = neg_count + CNT_W'(1);
            default:        ack_cnt_o = '0;
        endcase
    end

    always_comb begin
        if (mode_i == MASK_EVICT) inv_mask_o = sharers_i;
        else                      inv_mask_o = sharers_i & ~req_onehot;
    end

    // R9: the mask never names a node outside the sharer set
    p_mask_subset_r9: assert property (@(posedge clk) disable iff (rst)
        (inv_mask_o & ~sharers_i) == '0);

    // R2: an upgrade count never exceeds one
    p_upgrade_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (kind_i == RSP_UPGRADE) |-> (ack_cnt_o <= $signed(CNT_W'(1))));

    // R1: write data count is never positive beyond one
    p_write_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (kind_i == RSP_WRITE_DATA) |-> (ack_cnt_o <= $signed(CNT_W'(1))));
endmodule

// File: rtl/inv_pend_counter.sv
`timescale 1ns/1ps
module inv_pend_counter
    import inv_ack_pkg::*;
#(
    parameter int NODES = 8,
    parameter int POP_W = $clog2(NODES + 1),
    parameter int CNT_W = $clog2(NODES) + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [POP_W-1:0] load_val_i,
    input  logic             ack_valid_i,
    input  logic [CNT_W-1:0] ack_cnt_i,
    output logic [CNT_W-1:0] pending_o,
    output logic             partial_o,
    output logic             final_o
);
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] diff;
    ack_event_e       ev_q;
    ack_pulse_t       pulses;

    assign diff = pend_q - ack_cnt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            ev_q   <= EV_NONE;
        end else if (load_i) begin
            pend_q <= CNT_W'(load_val_i);
            ev_q   <= EV_NONE;
        end else if (ack_valid_i) begin
            if (diff == '0) begin
                pend_q <= '0;
                ev_q   <= EV_FINAL;
            end else begin
                pend_q <= diff;
                ev_q   <= EV_PARTIAL;
            end
        end else begin
            ev_q <= EV_NONE;
        end
    end

    assign pulses    = decode_event(ev_q);
    assign pending_o = pend_q;
    assign partial_o = pulses.partial;
    assign final_o   = pulses.final_ack;

    // R6: at most one of the two pulses
    p_one_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({partial_o, final_o}));

    // R4: a load lands as the counter value
    p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (pending_o == CNT_W'($past(load_val_i))));

    // R5: a final pulse always comes with an empty counter
    p_final_empty_r5: assert property (@(posedge clk) disable iff (rst)
        final_o |-> (pending_o == '0));

    // R7: no ack taken means no pulse afterwards
    p_no_ack_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !ack_valid_i |=> !(partial_o || final_o));

    // R8: a colliding load suppresses both pulses
    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (load_i && ack_valid_i) |=> !(partial_o || final_o));
endmodule

// File: rtl/inv_ack_tracker.sv
`timescale 1ns/1ps
module inv_ack_tracker
    import inv_ack_pkg::*;
#(
    parameter int NODES = 8,
    parameter int ID_W  = $clog2(NODES),
    parameter int POP_W = $clog2(NODES + 1),
    parameter int CNT_W = $clog2(NODES) + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NODES-1:0]        sharers_i,
    input  logic [ID_W-1:0]         req_id_i,
    input  logic [1:0]              rsp_kind_i,
    input  logic                    inv_mode_i,
    input  logic                    evict_load_i,
    input  logic                    ack_valid_i,
    input  logic [CNT_W-1:0]        ack_cnt_i,
    output logic signed [CNT_W-1:0] rsp_ack_cnt_o,
    output logic [NODES-1:0]        inv_mask_o,
    output logic [POP_W-1:0]        sharer_cnt_o,
    output logic [CNT_W-1:0]        pending_o,
    output logic                    ack_partial_o,
    output logic                    ack_final_o
);
    logic [POP_W-1:0] popcnt;
    rsp_kind_e        kind;
    mask_mode_e       mode;

    assign kind         = rsp_kind_e'(rsp_kind_i);
    assign mode         = mask_mode_e'(inv_mode_i);
    assign sharer_cnt_o = popcnt;

    inv_popcount #(.NODES(NODES), .POP_W(POP_W)) u_pop (
        .vec_i   (sharers_i),
        .count_o (popcnt)
    );

    inv_resp_calc #(.NODES(NODES), .ID_W(ID_W), .POP_W(POP_W), .CNT_W(CNT_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .sharers_i  (sharers_i),
        .req_id_i   (req_id_i),
        .kind_i     (kind),
        .mode_i     (mode),
        .popcnt_i   (popcnt),
        .ack_cnt_o  (rsp_ack_cnt_o),
        .inv_mask_o (inv_mask_o)
    );

    inv_pend_counter #(.NODES(NODES), .POP_W(POP_W), .CNT_W(CNT_W)) u_pend (
        .clk         (clk),
        .rst         (rst),
        .load_i      (evict_load_i),
        .load_val_i  (popcnt),
        .ack_valid_i (ack_valid_i),
        .ack_cnt_i   (ack_cnt_i),
        .pending_o   (pending_o),
        .partial_o   (ack_partial_o),
        .final_o     (ack_final_o)
    );

    // R11: sharer count never exceeds the node count
    p_count_range_r11: assert property (@(posedge clk) disable iff (rst)
        int'(sharer_cnt_o) <= NODES);
endmodule

// File: tb/tb_inv_ack_tracker.sv
`timescale 1ns/1ps
module tb_inv_ack_tracker;
    localparam int NODES = 8;
    localparam int ID_W  = 3;
    localparam int POP_W = 4;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NODES-1:0]        sharers_i = '0;
    logic [ID_W-1:0]         req_id_i = '0;
    logic [1:0]              rsp_kind_i = '0;
    logic                    inv_mode_i = 1'b0;
    logic                    evict_load_i = 1'b0;
    logic                    ack_valid_i = 1'b0;
    logic [CNT_W-1:0]        ack_cnt_i = '0;
    logic signed [CNT_W-1:0] rsp_ack_cnt_o;
    logic [NODES-1:0]        inv_mask_o;
    logic [POP_W-1:0]        sharer_cnt_o;
    logic [CNT_W-1:0]        pending_o;
    logic                    ack_partial_o;
    logic                    ack_final_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    inv_ack_tracker #(.NODES(NODES)) dut (
        .clk(clk), .rst(rst), .sharers_i(sharers_i), .req_id_i(req_id_i),
        .rsp_kind_i(rsp_kind_i), .inv_mode_i(inv_mode_i), .evict_load_i(evict_load_i),
        .ack_valid_i(ack_valid_i), .ack_cnt_i(ack_cnt_i), .rsp_ack_cnt_o(rsp_ack_cnt_o),
        .inv_mask_o(inv_mask_o), .sharer_cnt_o(sharer_cnt_o), .pending_o(pending_o),
        .ack_partial_o(ack_partial_o), .ack_final_o(ack_final_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pc(input logic [NODES-1:0] v);
        int n = 0;
        for (int i = 0; i < NODES; i++) n += int'(v[i]);
        return n;
    endfunction

    // drive one ack at a negedge, check after the next edge
    task automatic do_ack(input int cnt, input int pend_before, input string tag);
        int d;
        int exp_pend;
        ack_valid_i = 1'b1;
        ack_cnt_i   = CNT_W'(cnt);
        @(negedge clk);
        ack_valid_i = 1'b0;
        d = (pend_before - cnt) & 31;
        exp_pend = (d == 0) ? 0 : d;
        chk(ack_final_o == (d == 0), {tag, " final"}, int'(ack_final_o), int'(d == 0));
        chk(ack_partial_o == (d != 0), {tag, " partial"}, int'(ack_partial_o), int'(d != 0));
        chk(int'(pending_o) == exp_pend, {tag, " pending"}, int'(pending_o), exp_pend);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        int exp;
        int pend;
        logic [NODES-1:0] em;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(pending_o == '0, "R10 pending", int'(pending_o), 0);
        chk(!ack_final_o && !ack_partial_o, "R10 pulses", int'({ack_final_o, ack_partial_o}), 0);

        // combinational sweep: R1 R2 R3 R9 R11
        for (int s = 0; s < 256; s++) begin
            for (int id = 0; id < NODES; id++) begin
                for (int k = 0; k < 4; k++) begin
                    sharers_i  = NODES'(s);
                    req_id_i   = ID_W'(id);
                    rsp_kind_i = 2'(k);
                    inv_mode_i = 1'b0;
                    #1;
                    if (k == 0) begin
                        exp = -pc(NODES'(s)) + int'(sharers_i[id]);
                        chk(int'(rsp_ack_cnt_o) == exp, "R1 write count", int'(rsp_ack_cnt_o), exp);
                    end else if (k == 1) begin
                        exp = 1 - pc(NODES'(s));
                        chk(int'(rsp_ack_cnt_o) == exp, "R2 upgrade count", int'(rsp_ack_cnt_o), exp);
                    end else begin
                        chk(rsp_ack_cnt_o == 0, "R3 zero count", int'(rsp_ack_cnt_o), 0);
                    end
                    if (k == 0) begin
                        em = NODES'(s) & ~(NODES'(1) << id);
                        chk(inv_mask_o == em, "R9 write mask", int'(inv_mask_o), int'(em));
                        inv_mode_i = 1'b1;
                        #1;
                        chk(inv_mask_o == NODES'(s), "R9 evict mask", int'(inv_mask_o), s);
                        chk(int'(sharer_cnt_o) == pc(NODES'(s)), "R11 popcount",
                            int'(sharer_cnt_o), pc(NODES'(s)));
                    end
                end
            end
        end

        // eviction drain sweep: R4 R5 R6 R7
        @(negedge clk);
        for (int s = 0; s < 256; s++) begin
            sharers_i    = NODES'(s);
            evict_load_i = 1'b1;
            @(negedge clk);
            evict_load_i = 1'b0;
            pend = pc(NODES'(s));
            chk(int'(pending_o) == pend, "R4 load", int'(pending_o), pend);
            chk(!ack_final_o && !ack_partial_o, "R7 quiet after load",
                int'({ack_final_o, ack_partial_o}), 0);
            while (pend > 0) begin
                do_ack(1, pend, (pend == 1) ? "R5" : "R6");
                pend--;
            end
            if (pc(NODES'(s)) > 0) begin
                @(negedge clk);
                chk(!ack_final_o && !ack_partial_o, "R7 pulse one cycle",
                    int'({ack_final_o, ack_partial_o}), 0);
                chk(pending_o == '0, "R5 stays clear", int'(pending_o), 0);
            end
        end

        // multi-count acks
        sharers_i = 8'hFF;
        evict_load_i = 1'b1;
        @(negedge clk);
        evict_load_i = 1'b0;
        chk(int'(pending_o) == 8, "R4 full load", int'(pending_o), 8);
        do_ack(3, 8, "R6 multi");
        do_ack(5, 5, "R5 multi");
        // overshoot: ack larger than pending wraps, partial
        sharers_i = 8'h03;
        evict_load_i = 1'b1;
        @(negedge clk);
        evict_load_i = 1'b0;
        do_ack(3, 2, "R6 overshoot");

        // R8: load collides with an ack that would have been final
        sharers_i = 8'h01;
        evict_load_i = 1'b1;
        @(negedge clk);
        sharers_i = 8'h0F;
        ack_valid_i = 1'b1;
        ack_cnt_i = 5'd1;
        @(negedge clk);
        evict_load_i = 1'b0;
        ack_valid_i = 1'b0;
        chk(int'(pending_o) == 4, "R8 load wins", int'(pending_o), 4);
        chk(!ack_final_o && !ack_partial_o, "R8 no pulse", int'({ack_final_o, ack_partial_o}), 0);

        // R10: reset mid-count
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(pending_o == '0, "R10 reset clears", int'(pending_o), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule